// File: doc/BRIEF.md
# Level-Sensitive Interrupt Mask Unit

This unit sits next to a processor core and turns 32 level-sensitive interrupt request lines into one interrupt signal for the core. Each line passes through its own bit of an enable mask. The masked lines form a live pending view. The pending bits are OR-reduced into one combined request. That request is then gated by a global enable flag, which is bit 0 of a status register. Nothing is latched: if a source drops its request before it is serviced, the request also disappears from the pending view and from the output.

Software reaches the unit through a small register port. A 2-bit select picks the register: 0 is status, 1 is enable and 2 is pending. The port has a write strobe and 32-bit write and read data. Two command strobes set or clear a single enable bit named by a 5-bit line number, and leave the other bits as they are. An initialise strobe clears the whole mask and the global enable in one cycle.

Top module: `irq_mask_unit`

## Requirements
- R1: Reading select 2 returns the pending view `irq_lines & enable`, bit N for line N. It follows the inputs in the same cycle.
- R2: With status bit 0 set, `cpu_irq` is 1 exactly when at least one line is both asserted and enabled. It follows the inputs in the same cycle.
- R3: While status bit 0 is 0, `cpu_irq` is 0 whatever the lines and the mask hold.
- R4: A write to select 1 loads `reg_wdata` into the enable mask at the clock edge. Reading select 1 returns the mask.
- R5: A write to select 0 stores only `reg_wdata[0]` as the global enable. Reading select 0 returns that bit in position 0 and zeros in bits 31..1.
- R6: `bit_set` sets mask bit `bit_num` at the clock edge and leaves all other mask bits unchanged.
- R7: `bit_clr` clears mask bit `bit_num` at the clock edge and leaves all other mask bits unchanged. When `bit_set` and `bit_clr` are both high in the same cycle, the clear wins.
- R8: `init_cmd` clears the whole mask and the global enable at the clock edge. It takes priority over any register write or bit command in the same cycle.
- R9: Writes to select 2 or select 3 change nothing. Reading select 3 returns 0.
- R10: Synchronous reset clears the mask and the global enable, so `cpu_irq` is 0 after reset.
- R11: When a write to select 1 and a bit command fall in the same cycle, the written value is loaded and the bit command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the registers update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 32 | Level request lines, bit N is line N |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 pending, 3 unused |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| bit_set | input | 1 | Set the enable bit named by bit_num |
| bit_clr | input | 1 | Clear the enable bit named by bit_num |
| bit_num | input | 5 | Line number for the set and clear commands |
| init_cmd | input | 1 | Clear the whole mask and the global enable |
| cpu_irq | output | 1 | Gated interrupt request to the core |

## Verification
The unit holds only 33 bits of state: the enable mask and the global enable bit. A wrong mask bit shows up in the very next cycle, either in a read of select 1 or as a pending bit that is missing or should not be there when the matching line is driven high. A wrong global enable shows up on `cpu_irq` as soon as any enabled line is asserted. The bench therefore drives the lines all high or in varied patterns on most cycles, so that any damaged state reaches the ports within one cycle of the command that caused it.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int NUM_LINES = 32;
  localparam int DATA_W    = 32;
  localparam int LINE_W    = $clog2(NUM_LINES);

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_PENDING = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  // one-hot mask selecting a single request line
  function automatic logic [NUM_LINES-1:0] line_mask(input logic [LINE_W-1:0] n);
    logic [NUM_LINES-1:0] m;
    m = '0;
    m[n] = 1'b1;
    return m;
  endfunction

  // true when any line is both asserted and enabled
  function automatic logic any_live(input logic [NUM_LINES-1:0] pins,
                                    input logic [NUM_LINES-1:0] mask);
    return |(pins & mask);
  endfunction
endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_mask_pkg::*;
#(
  parameter int N_LINES = NUM_LINES,
  parameter int D_W     = DATA_W,
  parameter int L_W     = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  reg_sel_e           sel,
  input  logic               wr,
  input  logic [D_W-1:0]     wdata,
  input  logic               bit_set,
  input  logic               bit_clr,
  input  logic [L_W-1:0]     bit_num,
  input  logic               init_cmd,
  output logic [N_LINES-1:0] en_q,
  output logic               gie_q
);
  // named events, exposed for the assertions below
  logic init_evt, en_wr_evt, st_wr_evt, clr_evt, set_evt;
  logic [N_LINES-1:0] sel_bit;

  assign init_evt  = init_cmd;
  assign en_wr_evt = wr && (sel == SEL_ENABLE) && !init_cmd;
  assign st_wr_evt = wr && (sel == SEL_STATUS) && !init_cmd;
  assign clr_evt   = bit_clr && !init_cmd && !en_wr_evt;
  assign set_evt   = bit_set && !bit_clr && !init_cmd && !en_wr_evt;
  assign sel_bit   = line_mask(bit_num);

  always_ff @(posedge clk) begin
    if (rst || init_evt) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (st_wr_evt) gie_q <= wdata[0];
      if (en_wr_evt)    en_q <= wdata[N_LINES-1:0];
      else if (clr_evt) en_q <= en_q & ~sel_bit;
      else if (set_evt) en_q <= en_q | sel_bit;
    end
  end

  p_init_clears_r8: assert property (@(posedge clk) disable iff (rst)
    init_evt |=> (en_q == '0) && !gie_q);

  p_mask_write_r4: assert property (@(posedge clk) disable iff (rst)
    en_wr_evt |=> en_q == $past(wdata[N_LINES-1:0]));

  p_status_write_r5: assert property (@(posedge clk) disable iff (rst)
    st_wr_evt |=> gie_q == $past(wdata[0]));

  p_set_one_r6: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> en_q[$past(bit_num)] &&
      ((en_q & ~$past(sel_bit)) == ($past(en_q) & ~$past(sel_bit))));

  p_clr_one_r7: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> !en_q[$past(bit_num)] &&
      ((en_q & ~$past(sel_bit)) == ($past(en_q) & ~$past(sel_bit))));

  p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (en_wr_evt && (bit_set || bit_clr)) |=> en_q == $past(wdata[N_LINES-1:0]));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!init_evt && !en_wr_evt && !clr_evt && !set_evt) |=> $stable(en_q));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_mask_pkg::*;
#(
  parameter int N_LINES = NUM_LINES
) (
  input  logic [N_LINES-1:0] lines,
  input  logic [N_LINES-1:0] en,
  input  logic               gie,
  output logic [N_LINES-1:0] pending,
  output logic               combined,
  output logic               irq_out
);
  assign pending  = lines & en;
  assign combined = |pending;
  assign irq_out  = combined & gie;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_mask_pkg::*;
#(
  parameter int N_LINES = NUM_LINES,
  parameter int D_W     = DATA_W
) (
  input  reg_sel_e           sel,
  input  logic               gie,
  input  logic [N_LINES-1:0] en,
  input  logic [N_LINES-1:0] pending,
  output logic [D_W-1:0]     rdata
);
  always_comb begin
    unique case (sel)
      SEL_STATUS:  rdata = D_W'(gie);
      SEL_ENABLE:  rdata = D_W'(en);
      SEL_PENDING: rdata = D_W'(pending);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_pkg::*;
#(
  parameter int N_LINES = NUM_LINES,
  parameter int D_W     = DATA_W,
  parameter int L_W     = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic [1:0]         reg_sel,
  input  logic               reg_wr,
  input  logic [D_W-1:0]     reg_wdata,
  output logic [D_W-1:0]     reg_rdata,
  input  logic               bit_set,
  input  logic               bit_clr,
  input  logic [L_W-1:0]     bit_num,
  input  logic               init_cmd,
  output logic               cpu_irq
);
  reg_sel_e           sel_e;
  logic [N_LINES-1:0] en_q;
  logic               gie_q;
  logic [N_LINES-1:0] pending;
  logic               combined;

  assign sel_e = reg_sel_e'(reg_sel);

  irq_mask_regs #(.N_LINES(N_LINES), .D_W(D_W), .L_W(L_W)) u_regs (
    .clk(clk), .rst(rst), .sel(sel_e), .wr(reg_wr), .wdata(reg_wdata),
    .bit_set(bit_set), .bit_clr(bit_clr), .bit_num(bit_num),
    .init_cmd(init_cmd), .en_q(en_q), .gie_q(gie_q)
  );

  irq_gate #(.N_LINES(N_LINES)) u_gate (
    .lines(irq_lines), .en(en_q), .gie(gie_q),
    .pending(pending), .combined(combined), .irq_out(cpu_irq)
  );

  irq_read_mux #(.N_LINES(N_LINES), .D_W(D_W)) u_rmux (
    .sel(sel_e), .gie(gie_q), .en(en_q), .pending(pending), .rdata(reg_rdata)
  );

  p_pending_read_r1: assert property (@(posedge clk) disable iff (rst)
    (sel_e == SEL_PENDING) |-> reg_rdata == D_W'(irq_lines & en_q));

  p_irq_raise_r2: assert property (@(posedge clk) disable iff (rst)
    (gie_q && any_live(irq_lines, en_q)) |-> cpu_irq);

  p_irq_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!gie_q || !any_live(irq_lines, en_q)) |-> !cpu_irq);

  p_unused_read_r9: assert property (@(posedge clk) disable iff (rst)
    (sel_e == SEL_NONE) |-> reg_rdata == '0);
endmodule

// File: tb/irq_mask_unit_tb.sv
module irq_mask_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_lines = '0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bit_set = 1'b0, bit_clr = 1'b0, init_cmd = 1'b0;
  logic [4:0]  bit_num = '0;
  logic        cpu_irq;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit [31:0] m_mask = '0;
  bit        m_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mask_unit u_dut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bit_set(bit_set), .bit_clr(bit_clr), .bit_num(bit_num),
    .init_cmd(init_cmd), .cpu_irq(cpu_irq)
  );

  function automatic bit [31:0] exp_read(input int s, input bit [31:0] lines);
    if (s == 0) return {31'd0, m_on};
    if (s == 1) return m_mask;
    if (s == 2) begin
      bit [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = lines[i] && m_mask[i];
      return r;
    end
    return 32'd0;
  endfunction

  function automatic bit exp_irq(input bit [31:0] lines);
    bit hit = 1'b0;
    for (int i = 0; i < 32; i++) if (lines[i] && m_mask[i]) hit = 1'b1;
    return hit && m_on;
  endfunction

  // one clock cycle: drive, compare, then advance the model
  task automatic cyc(input string tag, input bit r, input bit [31:0] lines,
                     input int s, input bit w, input bit [31:0] wd,
                     input bit st, input bit cl, input int n, input bit in);
    string rt, it;
    bit [31:0] er;
    bit ei;
    @(negedge clk);
    rst = r; irq_lines = lines; reg_sel = 2'(s); reg_wr = w; reg_wdata = wd;
    bit_set = st; bit_clr = cl; bit_num = 5'(n); init_cmd = in;
    #1;
    if (!r) begin
      er = exp_read(s, lines);
      ei = exp_irq(lines);
      rt = (s == 0) ? "R5" : (s == 1) ? "R4" : (s == 2) ? "R1" : "R9";
      it = m_on ? "R2" : "R3";
      vectors++;
      if (reg_rdata !== er) begin
        fails++;
        $display("FAIL %s/%s rdata sel=%0d act=%h exp=%h", tag, rt, s, reg_rdata, er);
      end
      vectors++;
      if (cpu_irq !== ei) begin
        fails++;
        $display("FAIL %s/%s cpu_irq act=%b exp=%b", tag, it, cpu_irq, ei);
      end
    end
    @(posedge clk);
    if (r || in) begin
      m_mask = '0; m_on = 1'b0;
    end else begin
      if (w && s == 0) m_on = wd[0];
      if (w && s == 1) m_mask = wd;
      else if (cl) m_mask[n] = 1'b0;
      else if (st) m_mask[n] = 1'b1;
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc("R10", 1, '1, 1, 1, '1, 1, 0, 3, 0);
    // R10: after reset the mask and the enable read zero, output quiet
    cyc("R10", 0, '1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R10", 0, '1, 0, 0, 0, 0, 0, 0, 0);
    // R4: load the mask and read it back
    cyc("R4", 0, '0, 1, 1, 32'hA5A5_0F0F, 0, 0, 0, 0);
    cyc("R4", 0, '0, 1, 0, 0, 0, 0, 0, 0);
    // R1: pending view under several line patterns
    cyc("R1", 0, 32'hFFFF_FFFF, 2, 0, 0, 0, 0, 0, 0);
    cyc("R1", 0, 32'h0F0F_F0F0, 2, 0, 0, 0, 0, 0, 0);
    cyc("R1", 0, 32'h8000_0001, 2, 0, 0, 0, 0, 0, 0);
    // R3: global enable off keeps output low
    cyc("R3", 0, '1, 2, 0, 0, 0, 0, 0, 0);
    // R5: only bit 0 of status is stored
    cyc("R5", 0, '1, 0, 1, 32'hFFFF_FFFE, 0, 0, 0, 0);
    cyc("R5", 0, '1, 0, 1, 32'h0000_0001, 0, 0, 0, 0);
    cyc("R5", 0, '1, 0, 0, 0, 0, 0, 0, 0);
    // R2: enabled line raises output, masked lines do not
    cyc("R2", 0, 32'h0000_0001, 2, 0, 0, 0, 0, 0, 0);
    cyc("R2", 0, 32'h5A5A_F0F0, 2, 0, 0, 0, 0, 0, 0);
    cyc("R2", 0, 32'h0000_0000, 2, 0, 0, 0, 0, 0, 0);
    // R6: set line 4, others unchanged
    cyc("R6", 0, '0, 1, 0, 0, 1, 0, 4, 0);
    cyc("R6", 0, 32'h0000_0010, 1, 0, 0, 0, 0, 0, 0);
    // R7: clear line 0; set and clear together on line 9 clears
    cyc("R7", 0, '0, 1, 0, 0, 0, 1, 0, 0);
    cyc("R7", 0, '0, 1, 0, 0, 1, 1, 9, 0);
    cyc("R7", 0, '1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R7", 0, '0, 1, 0, 0, 1, 1, 2, 0);
    cyc("R7", 0, 32'h0000_0004, 2, 0, 0, 0, 0, 0, 0);
    // R11: mask write beats a same-cycle bit command
    cyc("R11", 0, '0, 1, 1, 32'h0000_F000, 1, 0, 3, 0);
    cyc("R11", 0, '0, 1, 1, 32'h0000_F000, 0, 1, 12, 0);
    cyc("R11", 0, '1, 1, 0, 0, 0, 0, 0, 0);
    // R9: writes to pending and unused select change nothing
    cyc("R9", 0, '1, 2, 1, 32'h1234_5678, 0, 0, 0, 0);
    cyc("R9", 0, '1, 3, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cyc("R9", 0, '1, 1, 0, 0, 0, 0, 0, 0);
    // R8: init clears everything even with a write and a set
    cyc("R8", 0, '1, 1, 1, 32'hFFFF_FFFF, 1, 0, 7, 1);
    cyc("R8", 0, '1, 1, 0, 0, 0, 0, 0, 0);
    cyc("R8", 0, '1, 0, 0, 0, 0, 0, 0, 0);
    // mixed traffic, each check tagged by the register it reads
    for (int k = 0; k < 3000; k++) begin
      bit [31:0] rl;
      int sv;
      rl = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      sv = $urandom % 4;
      cyc("MIX", 0, rl, sv, ($urandom % 3 == 0), $urandom,
          ($urandom % 3 == 0), ($urandom % 5 == 0), $urandom % 32,
          ($urandom % 40 == 0));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule